// File: doc/BRIEF.md
# Buffered Cycle Interrupt Timer

This block is a one-shot interrupt timer that counts CPU cycles. Software first writes the low byte of a 15-bit start value into a holding buffer. It then writes a high byte. That byte carries the upper seven bits of the value and a run bit. The high write moves the whole value into the counter, starts or stops the timer, and clears any pending interrupt.

While running, the counter steps down by one on every clock edge at which the CPU-cycle enable is high. When the counter passes below zero, the interrupt request goes high and the timer stops itself. The request stays high until software writes the high byte again or the block is reset.

The block sits behind an address decoder. The decoder turns CPU writes into the two write strobes and shares one 8-bit data bus between them.

Top module: `cyc_irq_timer`

## Requirements
- R1: A synchronous active-low reset clears the interrupt, stops the timer and zeroes both the counter and the low-byte buffer. A high write after reset with no low write therefore loads a low byte of 0.
- R2: A low write (`wr_lo`) stores `wr_data` in the buffer only. A running count keeps its value, and the interrupt still comes at the time it would have come without the write.
- R3: A high write (`wr_hi`) loads the counter with {`wr_data[6:0]`, buffer} and sets the run state to `wr_data[7]`. With the run bit set and a loaded value N, `irq` goes high at the (N+1)-th enabled tick edge after the load edge. This holds for N = 0 and for N = 32767.
- R4: The counter moves only on edges where the timer is running and `cyc_en` is high. Edges with `cyc_en` low do not advance the count.
- R5: On expiry `irq` goes high and the timer stops. `irq` then stays high until the next high write or a reset.
- R6: A high write clears `irq` at its own edge.
- R7: A high write with `wr_data[7]` = 0 leaves the timer stopped. No interrupt is raised, however many ticks follow.
- R8: When `wr_lo` and `wr_hi` are both high on the same edge, the load uses the incoming `wr_data` as the low byte, and the buffer also takes that byte.
- R9: A high write on the same edge as an enabled tick takes priority over the tick. This includes the tick that would have expired the timer: that expiry is lost and the new value is loaded.
- R10: The buffer keeps its byte across high writes. A later high write with no new low write reuses it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | One CPU cycle elapsed on this edge |
| wr_lo | input | 1 | Write strobe for the low-byte buffer |
| wr_hi | input | 1 | Write strobe for the high byte, run bit and interrupt clear |
| wr_data | input | 8 | Write data shared by both strobes |
| irq | output | 1 | Interrupt request, high from expiry until cleared |

## Verification
The bench builds the block with its default widths: an 8-bit low byte and a 7-bit high field, which gives a 15-bit count. These widths let it load the extremes 0 and 32767, and values that use the high field, such as 258 and 899. All of these expire within the run length. Directed loads aim at the corner edges: a high write on the would-be expiry tick, both strobes on one edge, a low write in the middle of a countdown, gaps in the cycle enable, and a reset during a countdown. A behavioural model predicts `irq` on every clock.

// File: rtl/cyc_irq_timer_pkg.sv
// Package: shared width constants for the buffered cycle interrupt timer.
// Assumes the low byte is as wide as the write data bus.
package cyc_irq_timer_pkg;
    parameter int unsigned TMR_DATA_W = 8;   // write bus and low-byte width
    parameter int unsigned TMR_HI_W   = 7;   // value bits carried by the high write
endpackage

// File: rtl/cyc_irq_lo_buf.sv
// Module: holds the low byte of the next start value.
// It also produces the effective low byte for a load that happens on the
// same edge as a low write, by bypassing the buffer with the incoming byte.
module cyc_irq_lo_buf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] eff_lo
);
    // capture the low byte on a low write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (wr) begin
            buf_q <= din;
        end
    end

    // low byte seen by a load on this edge
    always_comb begin
        eff_lo = wr ? din : buf_q;
    end
endmodule

// File: rtl/cyc_irq_down_cnt.sv
// Module: down counter with a run state.
// A load sets the value and the run state and takes priority over a tick.
// While running, each tick decrements the counter. A tick at zero wraps the
// counter, stops the run state and raises a one-cycle expire pulse.
module cyc_irq_down_cnt #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         load_run,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire
);
    logic step;

    // a counting step happens on an enabled tick not overridden by a load
    always_comb begin
        step   = running && tick && !load;
        expire = step && (count == '0);
    end

    // counter and run state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            running <= 1'b0;
        end else if (load) begin
            count   <= load_val;
            running <= load_run;
        end else if (step) begin
            count <= count - 1'b1;
            if (count == '0) begin
                running <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cyc_irq_flag.sv
// Module: sticky interrupt flag.
// Set by the expire pulse, cleared by an acknowledge. The acknowledge wins
// if both arrive on the same edge; the counter never pulses expire on a load edge.
module cyc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic flag_q
);
    // hold the request until acknowledged or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (ack_i) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end
    end
endmodule

// File: rtl/cyc_irq_timer.sv
// Module: buffered one-shot CPU-cycle interrupt timer (top).
// A low write fills a buffer. A high write loads {high bits, buffered low},
// sets the run state from the top data bit and clears the interrupt.
// Assumes HI_W < DATA_W, so the run bit sits above the value bits.
module cyc_irq_timer
    import cyc_irq_timer_pkg::*;
#(
    parameter int unsigned DATA_W = TMR_DATA_W,
    parameter int unsigned HI_W   = TMR_HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic              irq
);
    localparam int unsigned CNT_W  = DATA_W + HI_W;
    localparam int unsigned RUN_BIT = DATA_W - 1;

    logic [DATA_W-1:0] buf_q;
    logic [DATA_W-1:0] eff_lo;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt_q;
    logic              en_q;
    logic              expire;

    cyc_irq_lo_buf #(.W(DATA_W)) u_lo_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_lo),
        .din    (wr_data),
        .buf_q  (buf_q),
        .eff_lo (eff_lo)
    );

    // assemble the start value from the high field and the low byte
    always_comb begin
        load_val = {wr_data[HI_W-1:0], eff_lo};
    end

    cyc_irq_down_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cyc_en),
        .load     (wr_hi),
        .load_val (load_val),
        .load_run (wr_data[RUN_BIT]),
        .count    (cnt_q),
        .running  (en_q),
        .expire   (expire)
    );

    cyc_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .ack_i  (wr_hi),
        .flag_q (irq)
    );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
// Checker: temporal properties of the timer, bound into the top module.
module cyc_irq_timer_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HI_W   = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cyc_en,
    input logic                     wr_lo,
    input logic                     wr_hi,
    input logic [DATA_W-1:0]        wr_data,
    input logic                     irq,
    input logic [DATA_W+HI_W-1:0]   count,
    input logic                     enabled,
    input logic [DATA_W-1:0]        buf_q
);
    // R1: reset leaves everything cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !enabled && count == '0 && buf_q == '0));

    // R2: a low write alone leaves an idle count untouched
    assert_lo_keeps_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi && !(enabled && cyc_en)) |=> $stable(count));

    // R3 and R8: a high write loads the assembled value and the run bit
    assert_hi_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (count == {$past(wr_data[HI_W-1:0]), $past(wr_lo ? wr_data : buf_q)}
                   && enabled == $past(wr_data[DATA_W-1])));

    // R4: an enabled tick without a load decrements a nonzero count
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && enabled && cyc_en && count != '0) |=> (count == $past(count) - 1'b1));

    // R4 and R7: with no tick or no run state the count holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !(enabled && cyc_en)) |=> ($stable(count) && $stable(enabled)));

    // R5: expiry raises the request and stops the timer
    assert_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && enabled && cyc_en && count == '0) |=> (irq && !enabled));

    // R5: the request is sticky until a high write
    assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_hi) |=> irq);

    // R5: a fresh request always comes with a stopped timer
    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !enabled);

    // R6 and R9: a high write always clears the request
    assert_hi_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> !irq);

    // R10: without a low write the buffer keeps its byte
    assert_buf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(buf_q));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.DATA_W(DATA_W), .HI_W(HI_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_en  (cyc_en),
    .wr_lo   (wr_lo),
    .wr_hi   (wr_hi),
    .wr_data (wr_data),
    .irq     (irq),
    .count   (cnt_q),
    .enabled (en_q),
    .buf_q   (buf_q)
);

// File: tb/cyc_irq_timer_tb.sv
// Bench: behavioural model compared on every clock, plus directed checks.
module cyc_irq_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    int m_cnt = 0;
    int m_buf = 0;
    bit m_en  = 1'b0;
    bit m_irq = 1'b0;

    always #5 clk = ~clk;

    cyc_irq_timer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_en  (cyc_en),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .irq     (irq)
    );

    // reference model, updated at each rising edge from the inputs applied
    always @(posedge clk) begin
        int eff;
        if (!rst_n) begin
            m_cnt = 0; m_buf = 0; m_en = 1'b0; m_irq = 1'b0;
        end else begin
            eff = wr_lo ? int'(wr_data) : m_buf;
            if (wr_lo) m_buf = int'(wr_data);
            if (wr_hi) begin
                m_cnt = (int'(wr_data) % 128) * 256 + eff;
                m_en  = wr_data[7];
                m_irq = 1'b0;
            end else if (m_en && cyc_en) begin
                if (m_cnt == 0) begin
                    m_irq = 1'b1; m_en = 1'b0; m_cnt = 32767;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    // compare the output with the model away from the edge
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            total++;
            if (irq !== m_irq) begin
                bad++;
                $display("FAIL %s model compare at %0t: irq=%0b expected=%0b",
                         cur_req, $time, irq, m_irq);
            end
        end
    end

    task automatic check(input string req, input logic exp);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s directed at %0t: irq=%0b expected=%0b", req, $time, irq, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_low(input logic [7:0] d);
        wr_lo = 1'b1; wr_data = d;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic wr_high(input logic [7:0] d);
        wr_hi = 1'b1; wr_data = d;
        @(negedge clk);
        wr_hi = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired: irq=%0b expected=done", irq);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cmp_on = 1'b1;
        step(2);
        check("R1", 1'b0);                  // R1 during reset
        rst_n = 1'b1; cyc_en = 1'b1;
        step(20);
        check("R1", 1'b0);                  // R1 disabled after reset

        cur_req = "R3";
        wr_low(8'd5); wr_high(8'h80);       // R3 N=5
        step(5); check("R3", 1'b0);
        step(1); check("R3", 1'b1);

        cur_req = "R5";
        step(10); check("R5", 1'b1);        // R5 sticky

        cur_req = "R6";
        wr_high(8'h00); check("R6", 1'b0);  // R6 cleared by high write
        cur_req = "R7";
        step(50); check("R7", 1'b0);        // R7 stopped

        cur_req = "R3";
        wr_low(8'h02); wr_high(8'h81);      // R3 N=258
        step(258); check("R3", 1'b0);
        step(1); check("R3", 1'b1);

        cur_req = "R2";
        wr_low(8'd20); wr_high(8'h80);      // R2 N=20, low write mid-run
        step(5); wr_low(8'hFF);
        step(14); check("R2", 1'b0);
        step(1); check("R2", 1'b1);

        cur_req = "R10";
        wr_high(8'h80);                     // R10 reuse buffer 0xFF
        step(255); check("R10", 1'b0);
        step(1); check("R10", 1'b1);

        cur_req = "R4";
        wr_low(8'd4); wr_high(8'h80);       // R4 N=4 with gaps
        cyc_en = 1'b0; step(30); check("R4", 1'b0);
        for (int i = 0; i < 4; i++) begin
            cyc_en = 1'b1; step(1);
            cyc_en = 1'b0; step(1);
        end
        check("R4", 1'b0);
        cyc_en = 1'b1; step(1); check("R4", 1'b1);

        cur_req = "R8";
        wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h83;   // R8 N=0x383
        @(negedge clk);
        wr_lo = 1'b0; wr_hi = 1'b0;
        step(899); check("R8", 1'b0);
        step(1); check("R8", 1'b1);

        cur_req = "R9";
        wr_low(8'd2); wr_high(8'h80);       // R9 high write on expiry edge
        step(2); wr_high(8'h80);
        check("R9", 1'b0);
        step(2); check("R9", 1'b0);
        step(1); check("R9", 1'b1);

        cur_req = "R3";
        wr_low(8'd0); wr_high(8'h80);       // R3 N=0
        check("R3", 1'b0);
        step(1); check("R3", 1'b1);

        wr_low(8'hFF); wr_high(8'hFF);      // R3 N=32767
        step(32767); check("R3", 1'b0);
        step(1); check("R3", 1'b1);

        cur_req = "R1";
        wr_low(8'd10); wr_high(8'h80);      // R1 reset mid-run
        step(3);
        rst_n = 1'b0; step(1); check("R1", 1'b0);
        rst_n = 1'b1; step(30); check("R1", 1'b0);
        wr_high(8'h80);                     // R1 buffer was zeroed: N=0
        step(1); check("R1", 1'b1);

        step(2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule